// File: doc/BRIEF.md
# Line-Straddling Access Resolver

This block stands between a requester and a single cache tag directory. Each request is a byte address and a byte count. The block works out which cache lines the request covers. It then sends the directory one lookup for a request that stays inside one line, or two lookups for a request that crosses one line boundary. The directory's per-line answers are folded into one hit or miss verdict for the whole request.

A request that crosses a boundary is counted as one access. Its verdict is a hit only when both lines hit. The second line is still looked up when the first has already missed, so the directory updates its replacement state for both lines.

A request is rejected with an error flag, and no lookup is sent, in three cases:
- it covers more than two lines;
- its byte count is zero;
- its last byte lies beyond the top of the address space.

The directory is expected to answer each lookup in the cycle after the lookup is presented. The block accepts one request at a time, using a ready signal.

Top module: `straddle_resolver`

## Requirements
- R1: While reset is held and in the first cycle after it, `req_ready` is 1 and both `look_valid` and `res_valid` are 0.
- R2: The first line number is `req_addr >> log2(LINE_BYTES)`, and the last line number is `(req_addr + req_size - 1) >> log2(LINE_BYTES)`. For each looked-up line, `look_set` carries the low log2(SETS) bits of the line number and `look_tag` carries the remaining upper bits.
- R3: A request inside one line, accepted at clock edge E0, gets exactly one lookup. That lookup is shown in the cycle after E0 with `look_second`=0. The `dir_hit` value of the following cycle becomes `res_hit`, and it is shown with `res_valid` two cycles after the lookup.
- R4: For a two-line request accepted at edge E0:
  - the first line is looked up in the cycle after E0 with `look_second`=0;
  - the last line is looked up in the next cycle with `look_second`=1;
  - the second lookup is sent even when the first line missed.
- R5: A two-line request reports `res_hit`=1 only when both lookups hit, and gives a single `res_valid` pulse two cycles after the second lookup.
- R6: A request covering three or more lines, with `req_size`=0, or ending beyond the highest address gets no lookup. In the cycle after acceptance it shows `res_valid`=1, `res_err`=1 and `res_hit`=0.
- R7: `req_ready` is 0 from acceptance until the result cycle ends. A `req_valid` presented while `req_ready` is 0 is ignored.
- R8: `res_valid` lasts one cycle per accepted request, and `req_ready` returns to 1 in the following cycle. `res_err` is only ever 1 together with `res_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle; a request is taken on this edge |
| req_addr | input | ADDR_W | Byte address of the first byte |
| req_size | input | SIZE_W | Byte count of the request |
| look_valid | output | 1 | Lookup presented to the directory |
| look_second | output | 1 | 1 when the lookup is for the last line of a two-line request |
| look_set | output | log2(SETS) | Set index of the looked-up line |
| look_tag | output | ADDR_W-log2(LINE_BYTES)-log2(SETS) | Tag of the looked-up line |
| dir_hit | input | 1 | Directory verdict, valid the cycle after a lookup |
| res_valid | output | 1 | Merged result present |
| res_hit | output | 1 | Merged verdict: 1 only when every line hit |
| res_err | output | 1 | Request was illegal; no lookup made |

## Verification
The hardest cases to reach from the ports are the boundary ones:
- a request whose last byte falls exactly on the final byte of a line, against one that spills over by a single byte;
- a two-line request whose first line misses while its second hits, where the second lookup must still appear;
- a request that carries past the top of the address space.

Uniform random addresses and sizes rarely land on these. The stimulus therefore places offsets and sizes directly around line edges, the set-index wrap and the address ceiling. Random requests with random per-line directory answers are mixed in around them. Further requests are driven while the block is busy, to show that they are dropped.

// File: rtl/rsv_pkg.sv
// Shared types for the line-straddling access resolver.
// Assumes: nothing beyond the SystemVerilog base types.
package rsv_pkg;

    // Sequencer states: idle, first lookup, second lookup, last answer, result.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOK_A,
        ST_LOOK_B,
        ST_WAIT,
        ST_DONE
    } rsv_state_e;

    // How many cache lines a request covers.
    typedef enum logic [1:0] {
        SPAN_ONE,
        SPAN_TWO,
        SPAN_BAD
    } span_e;

endpackage

// File: rtl/rsv_span.sv
// Span calculator: turns a byte address and byte count into the first and
// last line numbers and classifies the request as one line, two lines or
// illegal (zero size, runs past the address top, or covers more than two lines).
// Assumes: purely combinational; the caller registers what it needs.
module rsv_span
    import rsv_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 5,
    parameter int OFF_W  = 4
) (
    input  logic [ADDR_W-1:0]       addr,
    input  logic [SIZE_W-1:0]       size,
    output logic [ADDR_W-OFF_W-1:0] first_line,
    output logic [ADDR_W-OFF_W-1:0] last_line,
    output span_e                   kind
);
    localparam int LINE_W = ADDR_W - OFF_W;

    logic [ADDR_W:0] end_byte;
    logic [LINE_W:0] gap;

    // Address of the final byte, with a carry bit for address-space overflow.
    always_comb begin
        end_byte = {1'b0, addr} + (ADDR_W+1)'(size) - (ADDR_W+1)'(1);
    end

    // Line numbers of the first and final byte.
    always_comb begin
        first_line = addr[ADDR_W-1:OFF_W];
        last_line  = end_byte[ADDR_W-1:OFF_W];
        gap        = {1'b0, last_line} - {1'b0, first_line};
    end

    // Classification of the request.
    always_comb begin
        if (size == '0 || end_byte[ADDR_W]) begin
            kind = SPAN_BAD;
        end else if (gap == '0) begin
            kind = SPAN_ONE;
        end else if (gap == (LINE_W+1)'(1)) begin
            kind = SPAN_TWO;
        end else begin
            kind = SPAN_BAD;
        end
    end

endmodule

// File: rtl/rsv_seq.sv
// Sequencer: walks a request through first lookup, optional second lookup,
// the wait for the last directory answer, and one result cycle.
// Illegal requests go straight to the result cycle.
// Assumes: the directory answers exactly one cycle after each lookup.
module rsv_seq
    import rsv_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  span_e      kind,
    output logic       accept,
    output rsv_state_e state
);
    logic two_q;

    // A request is taken only while idle.
    always_comb begin
        accept = (state == ST_IDLE) && req_valid;
    end

    // State register and the two-line flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            two_q <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        two_q <= (kind == SPAN_TWO);
                        state <= (kind == SPAN_BAD) ? ST_DONE : ST_LOOK_A;
                    end
                end
                ST_LOOK_A: state <= two_q ? ST_LOOK_B : ST_WAIT;
                ST_LOOK_B: state <= ST_WAIT;
                ST_WAIT:   state <= ST_DONE;
                ST_DONE:   state <= ST_IDLE;
                default:   state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/rsv_merge.sv
// Hit merger: starts as "hit" when the first lookup goes out, then ANDs in
// each directory answer it is told to sample.
// Assumes: clear and sample are never asserted together.
module rsv_merge (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic sample,
    input  logic dir_hit,
    output logic hit_all
);
    // Accumulate the AND of all answers for the current request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_all <= 1'b0;
        end else if (clear) begin
            hit_all <= 1'b1;
        end else if (sample) begin
            hit_all <= hit_all & dir_hit;
        end
    end

endmodule

// File: rtl/straddle_resolver.sv
// Line-straddling access resolver (top).
// Takes one byte-addressed request at a time. It issues one or two set/tag
// lookups to a tag directory and folds the answers into a single hit/miss
// result. Requests covering more than two lines are flagged as errors.
// Assumes: LINE_BYTES and SETS are powers of two, SETS >= 2, and the
// directory answers one cycle after each lookup.
module straddle_resolver
    import rsv_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int SIZE_W     = 5,
    parameter int LINE_BYTES = 16,
    parameter int SETS       = 64
) (
    input  logic                                                  clk,
    input  logic                                                  rst_n,
    input  logic                                                  req_valid,
    output logic                                                  req_ready,
    input  logic [ADDR_W-1:0]                                     req_addr,
    input  logic [SIZE_W-1:0]                                     req_size,
    output logic                                                  look_valid,
    output logic                                                  look_second,
    output logic [$clog2(SETS)-1:0]                               look_set,
    output logic [ADDR_W-$clog2(LINE_BYTES)-$clog2(SETS)-1:0]     look_tag,
    input  logic                                                  dir_hit,
    output logic                                                  res_valid,
    output logic                                                  res_hit,
    output logic                                                  res_err
);
    localparam int OFF_W  = $clog2(LINE_BYTES);
    localparam int SET_W  = $clog2(SETS);
    localparam int LINE_W = ADDR_W - OFF_W;

    logic [LINE_W-1:0] first_c, last_c;
    logic [LINE_W-1:0] first_q, last_q, line_sel;
    span_e             kind_c;
    logic              accept;
    logic              err_q;
    logic              hit_all;
    rsv_state_e        state;

    rsv_span #(
        .ADDR_W (ADDR_W),
        .SIZE_W (SIZE_W),
        .OFF_W  (OFF_W)
    ) u_span (
        .addr       (req_addr),
        .size       (req_size),
        .first_line (first_c),
        .last_line  (last_c),
        .kind       (kind_c)
    );

    rsv_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .kind      (kind_c),
        .accept    (accept),
        .state     (state)
    );

    rsv_merge u_merge (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (state == ST_LOOK_A),
        .sample  ((state == ST_LOOK_B) || (state == ST_WAIT)),
        .dir_hit (dir_hit),
        .hit_all (hit_all)
    );

    // Capture the line numbers and the error verdict of an accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_q <= '0;
            last_q  <= '0;
            err_q   <= 1'b0;
        end else if (accept) begin
            first_q <= first_c;
            last_q  <= last_c;
            err_q   <= (kind_c == SPAN_BAD);
        end
    end

    // Lookup outputs: pick the line for the current lookup and split it.
    always_comb begin
        look_valid  = (state == ST_LOOK_A) || (state == ST_LOOK_B);
        look_second = (state == ST_LOOK_B);
        line_sel    = look_second ? last_q : first_q;
        look_set    = line_sel[SET_W-1:0];
        look_tag    = line_sel[LINE_W-1:SET_W];
    end

    // Handshake and result outputs.
    always_comb begin
        req_ready = (state == ST_IDLE);
        res_valid = (state == ST_DONE);
        res_err   = res_valid && err_q;
        res_hit   = res_valid && !err_q && hit_all;
    end

endmodule

// File: rtl/rsv_checker.sv
// Protocol checker for straddle_resolver, attached by bind. It observes
// ports only.
module rsv_checker #(
    parameter int ADDR_W = 32,
    parameter int OFF_W  = 4,
    parameter int SET_W  = 6
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            req_valid,
    input logic                            req_ready,
    input logic [ADDR_W-1:0]               req_addr,
    input logic                            look_valid,
    input logic                            look_second,
    input logic [SET_W-1:0]                look_set,
    input logic [ADDR_W-OFF_W-SET_W-1:0]   look_tag,
    input logic                            res_valid,
    input logic                            res_hit,
    input logic                            res_err
);
    assert_reset_R1: assert property (@(posedge clk)
        !rst_n |=> (req_ready && !look_valid && !res_valid));

    assert_first_line_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (look_valid && !look_second) |->
            ({look_tag, look_set} == $past(req_addr[ADDR_W-1:OFF_W])));

    assert_result_timing_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_err) |-> ($past(look_valid, 2) && !$past(look_valid, 1)));

    assert_second_after_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (look_valid && look_second) |-> $past(look_valid && !look_second));

    assert_error_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_err) |->
            (!res_hit && !look_valid && $past(req_valid && req_ready)));

    assert_busy_after_take_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    assert_lookup_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        look_valid |-> !req_ready);

    assert_result_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> (!res_valid && req_ready));

    assert_err_with_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        res_err |-> res_valid);

endmodule

bind straddle_resolver rsv_checker #(
    .ADDR_W (ADDR_W),
    .OFF_W  (OFF_W),
    .SET_W  (SET_W)
) u_rsv_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_addr    (req_addr),
    .look_valid  (look_valid),
    .look_second (look_second),
    .look_set    (look_set),
    .look_tag    (look_tag),
    .res_valid   (res_valid),
    .res_hit     (res_hit),
    .res_err     (res_err)
);

// File: tb/tb_straddle_resolver.sv
// Bench for straddle_resolver: directed line-edge cases plus seeded random
// requests, each checked cycle by cycle against bench-computed expectations.
module tb_straddle_resolver;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 32;
    localparam int SIZE_W = 5;
    localparam int OFF_W  = 4;
    localparam int SET_W  = 6;
    localparam int TAG_W  = ADDR_W - OFF_W - SET_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [SIZE_W-1:0] req_size = '0;
    logic              look_valid, look_second;
    logic [SET_W-1:0]  look_set;
    logic [TAG_W-1:0]  look_tag;
    logic              dir_hit = 1'b0;
    logic              res_valid, res_hit, res_err;

    int total = 0;
    int bad   = 0;
    bit ended = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    straddle_resolver #(
        .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .LINE_BYTES(16), .SETS(64)
    ) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_size(req_size), .look_valid(look_valid),
        .look_second(look_second), .look_set(look_set), .look_tag(look_tag),
        .dir_hit(dir_hit), .res_valid(res_valid), .res_hit(res_hit), .res_err(res_err)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int span_of(input logic [ADDR_W-1:0] a, input logic [SIZE_W-1:0] s);
        logic [ADDR_W:0] e;
        logic [ADDR_W-OFF_W-1:0] f, l;
        e = {1'b0, a} + (ADDR_W+1)'(s) - (ADDR_W+1)'(1);
        f = a[ADDR_W-1:OFF_W];
        l = e[ADDR_W-1:OFF_W];
        if (s == 0 || e[ADDR_W]) return 3;
        if (l == f) return 1;
        if (l == f + 1) return 2;
        return 3;
    endfunction

    function automatic logic [ADDR_W-OFF_W-1:0] line_of(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1:OFF_W];
    endfunction

    task automatic run_access(input logic [ADDR_W-1:0] a, input logic [SIZE_W-1:0] s,
                              input bit h1, input bit h2);
        int n;
        logic [ADDR_W-OFF_W-1:0] fl, ll;
        n  = span_of(a, s);
        fl = line_of(a);
        ll = line_of(a + ADDR_W'(s) - 1);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_size = s; dir_hit = $urandom_range(0, 1) == 1;
        @(negedge clk);
        // busy-time noise on the request port (R7)
        req_addr = $urandom; req_size = SIZE_W'($urandom_range(1, 31));
        check(!req_ready, "R7 ready low after take", req_ready, 0);
        if (n == 3) begin
            check(res_valid && res_err && !res_hit && !look_valid, "R6 illegal result",
                  {res_valid, res_err, res_hit, look_valid}, 4'b1100);
            req_valid = 1'b0;
        end else begin
            check(look_valid && !look_second, "R3 R4 first lookup", {look_valid, look_second}, 2'b10);
            check({look_tag, look_set} == fl, "R2 first line set/tag", {look_tag, look_set}, fl);
            dir_hit = !h1;
            @(negedge clk);
            dir_hit = h1;
            if (n == 2) begin
                check(look_valid && look_second, "R4 second lookup", {look_valid, look_second}, 2'b11);
                check({look_tag, look_set} == ll, "R2 last line set/tag", {look_tag, look_set}, ll);
            end else begin
                check(!look_valid && !res_valid, "R3 single lookup only", {look_valid, res_valid}, 0);
            end
            @(negedge clk);
            if (n == 2) begin
                dir_hit = h2;
                check(!look_valid && !res_valid && !req_ready, "R5 R7 waiting",
                      {look_valid, res_valid, req_ready}, 0);
                @(negedge clk);
                dir_hit = $urandom_range(0, 1) == 1;
                check(res_valid && !res_err && res_hit == (h1 && h2), "R5 merged verdict",
                      {res_valid, res_err, res_hit}, {2'b10, h1 && h2});
            end else begin
                dir_hit = $urandom_range(0, 1) == 1;
                check(res_valid && !res_err && res_hit == h1, "R3 single verdict",
                      {res_valid, res_err, res_hit}, {2'b10, h1});
            end
            check(!req_ready, "R7 ready low in result cycle", req_ready, 0);
            req_valid = 1'b0;
        end
        @(negedge clk);
        check(req_ready && !res_valid && !look_valid, "R8 one pulse then idle",
              {req_ready, res_valid, look_valid}, 3'b100);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!ended) begin
            ended = 1;
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        check(req_ready && !look_valid && !res_valid, "R1 during reset",
              {req_ready, look_valid, res_valid}, 3'b100);
        @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready && !look_valid && !res_valid, "R1 after reset",
              {req_ready, look_valid, res_valid}, 3'b100);

        // directed corner cases
        run_access(32'h0000_1000, 5'd4,  1, 0);  // R3 one line, hit
        run_access(32'h0000_1004, 5'd4,  0, 0);  // R3 one line, miss
        run_access(32'h0000_100F, 5'd1,  1, 0);  // last byte of a line
        run_access(32'h0000_2000, 5'd16, 1, 0);  // whole aligned line
        run_access(32'h0000_100F, 5'd2,  1, 1);  // R5 spill by one, both hit
        run_access(32'h0000_100E, 5'd4,  1, 0);  // R5 second misses
        run_access(32'h0000_100E, 5'd4,  0, 1);  // R4 first misses, second still looked up
        run_access(32'h0000_100E, 5'd4,  0, 0);  // R5 both miss: one miss
        run_access(32'h0000_2000, 5'd17, 1, 1);  // aligned, one byte over
        run_access(32'h0000_03F8, 5'd16, 1, 1);  // set index wraps 63 -> 0
        run_access(32'h0000_3001, 5'd31, 1, 1);  // longest legal two-line span
        run_access(32'h0000_3002, 5'd31, 1, 1);  // R6 three lines
        run_access(32'h0000_3000, 5'd0,  1, 1);  // R6 zero size
        run_access(32'hFFFF_FFFF, 5'd2,  1, 1);  // R6 past address top
        run_access(32'hFFFF_FFF0, 5'd16, 1, 0);  // top line, legal

        for (int i = 0; i < 400; i++) begin
            run_access($urandom, SIZE_W'($urandom_range(0, 31)),
                       $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1);
        end

        if (!ended) begin
            ended = 1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule